// File: doc/BRIEF.md
# Pipelined Burst Memory Access Controller

This block is the control front end of a small synchronous burst memory. On every rising clock edge it samples two address-status strobes (one meant for a processor, one for a cache controller), three chip selects, a burst-advance input, a global write enable, a byte-write enable and one write enable per byte lane. From these it decides whether the edge starts a new access, continues a burst, deselects the device or does nothing. It then writes the selected byte lanes of an internal array, or reads the array through a two-register pipeline.

A burst covers four words. The external address supplies the upper bits and the starting offset. A two-bit counter then walks the low bits, in linear or in interleaved order, and wraps after the fourth word. The data bus is modelled by a data output and a drive flag. The drive flag is gated without a clock by the output-enable input, by any write edge, and by a power-down input. Array contents survive power-down, and the block ignores commands for a fixed number of edges after power-down ends.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An edge where `adsp_n` is low and all three selects are active (`ce1_n` low, `ce2` high, `ce3_n` low) starts a read at `addr`. This holds whatever `adsc_n` and all write enables are doing.
- R2: While `ce1_n` is high, a low `adsp_n` is blocked and starts nothing. No read data comes out and no burst begins.
- R3: An edge where `adsc_n` is low and the processor strobe is not effective starts an access at `addr`. The write enables sampled on that same edge decide between write and read.
- R4: The write enables have no effect on a processor-strobe start edge. On later continuation edges of the burst they are sampled and can write.
- R5: Lane i covers `din`/`dout` bits [9i+8:9i], which are eight data bits and one parity bit. `gwe_n` low writes every lane. With `gwe_n` high, lane i is written only when `bwe_n` and `lane_we_n[i]` are both low.
- R6: Take a read accessed on edge k. Its word appears on `dout` after edge k+1, and `dout_valid` is high while `oe_n` is low.
- R7: On a continuation edge, `adv_n` low advances the two-bit burst offset n. The address low bits are (a+n) mod 4 when `interleave` is low and a XOR n when it is high. The offset wraps after four words, `adv_n` high repeats the current word, and the upper address bits stay fixed.
- R8: An edge that writes stores `din` into the enabled lanes and holds `dout_valid` low for the following cycle, whatever `oe_n` is.
- R9: `oe_n` high forces `dout_valid` low at once, without a clock edge.
- R10: While `sleep` is high, `dout_valid` is low and the array keeps its contents. After `sleep` falls, the first WAKE_CYC (2) edges ignore all commands.
- R11: A start edge with any select inactive is a deselect. It ends the burst, and the word already in the pipeline is still delivered after the next edge. After that, `dout_valid` is low and continuation edges do nothing.
- R12: After reset, `dout_valid` and `dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select 1, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| gwe_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Start address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data from the output register |
| dout_valid | output | 1 | Output drive flag |

## Verification
A wrong start decision or wrong write-enable sampling corrupts a word in the array. That error stays hidden until the word is read back, two edges after the read is accepted. A wrong burst offset puts the wrong word on `dout` in the very cycle it would have been valid. Errors in the pipeline, the wake counter or the deselect logic show up on `dout_valid` one or two edges after the edge that caused them.

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
  parameter int AW       = 6,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gwe_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    interleave,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_valid
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;
  localparam int WKW   = $clog2(WAKE_CYC + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             active_q, v1_q, v2_q, wr_q;
  logic [DW-1:0]    stage_q, dout_q;
  logic [WKW-1:0]   wake_q;

  logic             sel, awake, p_req, c_req, start, go_p, go_c, desel, cont;
  logic [LANES-1:0] lane_wr, wstb;
  logic             wr_any, do_write, do_read;
  logic [1:0]       cnt_nx, lo_base, off, lo;
  logic [AW-1:0]    base_sel, acc_addr;

  assign sel   = !ce1_n && ce2 && !ce3_n;
  assign awake = !sleep && (wake_q == '0);
  assign p_req = !adsp_n && !ce1_n;
  assign c_req = !adsc_n && !p_req;
  assign start = awake && (p_req || c_req);
  assign go_p  = start && p_req && sel;
  assign go_c  = start && c_req && sel;
  assign desel = start && !sel;
  assign cont  = awake && !start && active_q;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_wr[i] = !gwe_n || (!bwe_n && !lane_we_n[i]);
  end

  assign wr_any   = |lane_wr;
  assign do_write = (go_c || cont) && wr_any;
  assign do_read  = go_p || ((go_c || cont) && !wr_any);
  assign wstb     = do_write ? lane_wr : '0;

  assign cnt_nx   = (cont && !adv_n) ? 2'(cnt_q + 2'd1) : cnt_q;
  assign base_sel = start ? addr : base_q;
  assign lo_base  = base_sel[1:0];
  assign off      = start ? 2'd0 : cnt_nx;
  assign lo       = interleave ? (lo_base ^ off) : 2'(lo_base + off);
  assign acc_addr = {base_sel[AW-1:2], lo};

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wstb[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    if (do_read) stage_q <= mem[acc_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      v1_q     <= 1'b0;
      v2_q     <= 1'b0;
      wr_q     <= 1'b0;
      wake_q   <= '0;
      dout_q   <= '0;
    end else if (sleep) begin
      wake_q   <= WKW'(WAKE_CYC);
      active_q <= 1'b0;
      v1_q     <= 1'b0;
      v2_q     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      if (wake_q != '0) wake_q <= wake_q - 1'b1;
      v1_q <= do_read;
      v2_q <= v1_q;
      wr_q <= do_write;
      if (v1_q) dout_q <= stage_q;
      if (start) begin
        active_q <= sel;
        base_q   <= addr;
        cnt_q    <= '0;
      end else if (cont) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign dout       = dout_q;
  assign dout_valid = v2_q && !oe_n && !sleep && !wr_q;
endmodule

module burst_sram_ctrl_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic             gwe_n,
  input logic             dout_valid,
  input logic             do_write,
  input logic             desel,
  input logic             go_p,
  input logic [LANES-1:0] wstb
);
  assert_pstart_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go_p |-> (wstb == '0));
  assert_global_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !gwe_n) |-> (&wstb));
  assert_write_mutes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> !dout_valid);
  assert_wake_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !dout_valid);
  assert_deselect_drains_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desel |-> ##2 !dout_valid);
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .gwe_n(gwe_n),
  .dout_valid(dout_valid), .do_write(do_write), .desel(desel),
  .go_p(go_p), .wstb(wstb)
);

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;
  localparam int AW = 6, LANES = 2, LANE_W = 9, DW = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gwe_n, bwe_n, oe_n, sleep, interleave;
  logic [LANES-1:0] lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_valid;
  logic [DW-1:0] mdl [64];
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(2)) uut (.*);

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'((a * 2731 + 97 + salt * 5003) ^ (a << 9));
  endfunction

  function automatic logic [AW-1:0] seq(logic [AW-1:0] a, int n, bit il);
    logic [1:0] lo;
    lo = il ? (a[1:0] ^ 2'(n)) : 2'(a[1:0] + 2'(n));
    return {a[AW-1:2], lo};
  endfunction

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gwe_n = 1; bwe_n = 1; lane_we_n = '1; sleep = 0; oe_n = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic read_word(logic [AW-1:0] a, string req);
    idle(); adsp_n = 0; addr = a; tick();
    idle(); tick();
    chk(req, {31'd0, dout_valid}, 32'd1);
    chk(req, 32'(dout), 32'(mdl[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(); interleave = 0; addr = '0;
    repeat (3) tick();
    chk("R12", {31'd0, dout_valid}, 0);
    chk("R12", 32'(dout), 0);
    rst_n = 1; tick();

    // R3 controller start writes, continuation writes fill the array
    for (int b = 0; b < 64; b += 4) begin
      for (int j = 0; j < 4; j++) begin
        idle(); gwe_n = 0; adv_n = (j == 0); din = pat(b + j, 0);
        if (j == 0) begin adsc_n = 0; addr = AW'(b); end
        tick();
        mdl[b + j] = pat(b + j, 0);
        chk("R8", {31'd0, dout_valid}, 0);
      end
    end

    // R1 R4 R6 R7: every start address, both orders, strobes and writes noise on start edge
    for (int il = 0; il < 2; il++) begin
      interleave = il[0];
      for (int a = 0; a < 64; a++) begin
        idle(); adsp_n = 0; adsc_n = 0; gwe_n = 0; addr = AW'(a); tick();
        for (int n = 0; n < 5; n++) begin
          idle(); adv_n = 0; tick();
          chk("R6", {31'd0, dout_valid}, 1);
          chk("R7", 32'(dout), 32'(mdl[seq(AW'(a), n, il[0])]));
        end
      end
    end
    interleave = 0;

    // R7 hold with adv high
    idle(); adsp_n = 0; addr = 6'd6; tick();
    idle(); adv_n = 0; tick(); chk("R7", 32'(dout), 32'(mdl[6]));
    idle(); adv_n = 1; tick(); chk("R7", 32'(dout), 32'(mdl[7]));
    idle(); adv_n = 0; tick(); chk("R7", 32'(dout), 32'(mdl[7]));
    idle(); tick();            chk("R7", 32'(dout), 32'(mdl[4]));

    // R5 byte lanes: lane i = bits [9i+8:9i]
    for (int bw = 0; bw < 2; bw++) begin
      for (int m = 0; m < 4; m++) begin
        logic [AW-1:0] wa;
        wa = AW'(32 + bw * 4 + m);
        idle(); adsc_n = 0; addr = wa; bwe_n = bw[0]; lane_we_n = ~2'(m);
        din = pat(wa, 7); tick();
        for (int l = 0; l < LANES; l++)
          if (!bw[0] && m[l]) mdl[wa][l*LANE_W +: LANE_W] = din[l*LANE_W +: LANE_W];
        read_word(wa, "R5");
      end
    end
    idle(); adsc_n = 0; addr = 6'd44; gwe_n = 0; bwe_n = 1; lane_we_n = '1;
    din = pat(44, 9); tick(); mdl[44] = din;
    read_word(6'd44, "R5");

    // R4 R8: continuation write after processor start; output muted
    idle(); adsp_n = 0; addr = 6'd50; gwe_n = 0; tick();
    idle(); adv_n = 1; gwe_n = 0; din = pat(50, 3); tick(); mdl[50] = pat(50, 3);
    chk("R8", {31'd0, dout_valid}, 0);
    read_word(6'd50, "R4");

    // R9 asynchronous output enable
    idle(); adsp_n = 0; addr = 6'd3; tick(); idle(); tick();
    chk("R9", {31'd0, dout_valid}, 1);
    oe_n = 1; #1; chk("R9", {31'd0, dout_valid}, 0);
    oe_n = 0; #1; chk("R9", {31'd0, dout_valid}, 1);

    // R11 deselect drains then stops
    idle(); adsp_n = 0; addr = 6'd9; tick();
    idle(); adsc_n = 0; ce3_n = 1; tick();
    chk("R11", {31'd0, dout_valid}, 1);
    chk("R11", 32'(dout), 32'(mdl[9]));
    idle(); adv_n = 0; tick();
    chk("R11", {31'd0, dout_valid}, 0);
    idle(); adv_n = 0; gwe_n = 0; din = 18'h3ffff; tick(); tick();
    chk("R11", {31'd0, dout_valid}, 0);
    read_word(6'd10, "R11"); read_word(6'd11, "R11");

    // R2 processor strobe blocked by ce1_n
    idle(); adsc_n = 0; ce2 = 0; tick(); idle(); tick();
    idle(); adsp_n = 0; ce1_n = 1; addr = 6'd12; tick();
    idle(); tick(); tick();
    chk("R2", {31'd0, dout_valid}, 0);

    // R10 power-down, retention, wake-up ignore window
    idle(); adsp_n = 0; addr = 6'd20; tick();
    idle(); sleep = 1; #1; chk("R10", {31'd0, dout_valid}, 0);
    tick(); tick(); chk("R10", {31'd0, dout_valid}, 0);
    for (int e = 0; e < 2; e++) begin
      idle(); adsc_n = 0; addr = 6'd21; gwe_n = 0; din = 18'h15555; tick();
      chk("R10", {31'd0, dout_valid}, 0);
    end
    read_word(6'd21, "R10");
    read_word(6'd20, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule